// File: doc/BRIEF.md
# SPI Control Register File

This block is the control core of a small board-management device. A host reaches it through a four-wire serial slave port. The port uses clock polarity 0 and phase 0. Each transaction is a single 24-bit frame. The frame holds a direction flag, a 7-bit register address and a 16-bit data word. For a read, the slave returns the register contents on the data-out line during the last sixteen clocks of the same frame.

The register file holds several kinds of register. Constant identity words report the signature, revision, oldest compatible revision and a 32-bit build code. A scratch word lets software test the link. Three control bits drive pins or internal state: a hold-style global clear, a bit that hands the oscillator tuning voltage to the phase DAC, and a transceiver hard reset. One status word reports two LO lock inputs after synchronisation.

The block runs from a single system clock. The serial clock, chip select and data-in are oversampled through synchronizers, and edges are detected in the system clock domain. The serial clock must therefore be several times slower than the system clock.

Top module: `spi_ctrl_regfile`

## Requirements
- R1: A frame is 24 bits long and is shifted MSB first while chip select is low. Data-in is sampled on rising serial clock edges, and the serial clock idles low. Frame bit 23 = 1 selects a read and 0 selects a write. Bits 22:16 carry the address and bits 15:0 carry the data.
- R2: Address 0x00 reads as 0xCAFE and address 0x01 reads as 4. A write to either address leaves the read value unchanged.
- R3: Address 0x02 reads the oldest compatible revision (default 2). Address 0x03 reads the low half of the build code and 0x04 reads the high half (default build code 0x19102A7C).
- R4: Address 0x05 is a scratch word that reads back the last committed write.
- R5: Address 0x10 bit 0 is a global clear and reads back at bit 0. While it is 1, the scratch word, the 0x11 control bit and the 0x13 control bit are held at 0, and writes to those registers are lost. Writing 0 releases the clear.
- R6: Address 0x11 bit 4 drives `dac_owns_vcxo` and reads back at bit 4. The other bits of 0x11 read 0.
- R7: Address 0x12 is read-only. Bit 0 shows `rx_lo_locked` and bit 4 shows `tx_lo_locked`, each after a two-flop synchronizer. A write to 0x12 has no effect.
- R8: Address 0x13 bit 0 drives `xcvr_hard_reset` and reads back at bit 0. The output stays asserted until a 0 is written (or the global clear acts).
- R9: `spi_miso` carries the read data MSB first during frame bits 15:0 of a read frame and changes only after falling serial clock edges. It is 0 during frame bits 23:16, during write frames and while chip select is high.
- R10: A write commits only when chip select rises after exactly 24 rising serial clock edges. Frames of 23 or 25 bits leave every register unchanged.
- R11: Reading an unmapped address returns 0x0000. Writing an unmapped address changes nothing.
- R12: Synchronous reset clears every writable register, drives both control outputs low and drives `spi_miso` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host |
| rx_lo_locked | input | 1 | Receive LO lock status |
| tx_lo_locked | input | 1 | Transmit LO lock status |
| dac_owns_vcxo | output | 1 | Phase DAC has exclusive control of the oscillator tuning voltage |
| xcvr_hard_reset | output | 1 | Hard reset to the transceiver |

## Verification
A write commit can fall in the same cycle as an active global clear, and the clear must win. The bench provokes this by writing 1 to the clear bit and then committing writes to the scratch word and both control registers while the clear is held. It judges the result through the control pins, which the bench compares every idle clock, and by reading back the scratch word, which must return 0 both during the hold and after release. Truncated and overlong frames sent to the same registers show that an incomplete frame never reaches that commit point.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    localparam int unsigned FRAME_W = 24;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned ADDR_W  = 7;
    localparam int unsigned HDR_W   = ADDR_W + 1;
    localparam int unsigned CNT_W   = $clog2(FRAME_W) + 1;

    localparam int unsigned GLB_BIT   = 0;
    localparam int unsigned EXCL_BIT  = 4;
    localparam int unsigned RXLK_BIT  = 0;
    localparam int unsigned TXLK_BIT  = 4;
    localparam int unsigned XRST_BIT  = 0;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [ADDR_W-1:0] {
        A_SIG     = 7'h00,
        A_REV     = 7'h01,
        A_COMPAT  = 7'h02,
        A_BLD_LO  = 7'h03,
        A_BLD_HI  = 7'h04,
        A_SCRATCH = 7'h05,
        A_GLB     = 7'h10,
        A_CLKPATH = 7'h11,
        A_STATUS  = 7'h12,
        A_XCVR    = 7'h13
    } reg_addr_e;

    typedef struct packed {
        logic                rd;
        logic [ADDR_W-1:0]   addr;
    } hdr_t;

    typedef struct packed {
        logic [ADDR_W-1:0]   addr;
        word_t               data;
    } wr_req_t;

    function automatic word_t place_bit(input int unsigned pos, input logic v);
        word_t w;
        w      = '0;
        w[pos] = v;
        return w;
    endfunction

endpackage

// File: rtl/spi_regs_sync.sv
module spi_regs_sync #(
    parameter int unsigned        WIDTH   = 1,
    parameter int unsigned        STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= RST_VAL;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_regs_frontend.sv
module spi_regs_frontend
    import spi_regs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_s,
    input  logic    cs_n_s,
    input  logic    mosi_s,
    input  word_t   rd_data,
    output hdr_t    hdr,
    output logic    wr_en,
    output wr_req_t wr_req,
    output logic    miso
);

    logic               sclk_d;
    logic               cs_d;
    logic               rise;
    logic               fall;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] shreg;
    logic               ld_pend;
    word_t              rd_word;
    logic [3:0]         bit_idx;
    logic               in_data;

    assign rise    = sclk_s & ~sclk_d & ~cs_n_s;
    assign fall    = ~sclk_s & sclk_d & ~cs_n_s;
    assign bit_idx = 4'(CNT_W'(FRAME_W - 1) - cnt);
    assign in_data = (cnt >= CNT_W'(HDR_W)) && (cnt < CNT_W'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
            cnt     <= '0;
            shreg   <= '0;
            hdr     <= '0;
            ld_pend <= 1'b0;
            rd_word <= '0;
            miso    <= 1'b0;
        end else begin
            sclk_d  <= sclk_s;
            cs_d    <= cs_n_s;
            ld_pend <= 1'b0;
            if (cs_n_s) begin
                cnt  <= '0;
                miso <= 1'b0;
            end else begin
                if (rise) begin
                    shreg <= {shreg[FRAME_W-2:0], mosi_s};
                    if (cnt != '1) cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(HDR_W - 1)) begin
                        hdr     <= hdr_t'({shreg[HDR_W-2:0], mosi_s});
                        ld_pend <= 1'b1;
                    end
                end
                if (ld_pend) rd_word <= hdr.rd ? rd_data : '0;
                if (fall)    miso    <= in_data ? rd_word[bit_idx] : 1'b0;
            end
        end
    end

    assign wr_en  = cs_n_s & ~cs_d & (cnt == CNT_W'(FRAME_W)) & ~shreg[FRAME_W-1];
    assign wr_req = wr_req_t'(shreg[FRAME_W-2:0]);

    // R10: a commit always ends the frame and restarts the bit count
    a_r10_commit_restarts: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == '0));

    // R9: data-out is quiet while deselected
    a_r9_miso_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !miso);

    // R9: data-out moves only on a falling serial clock edge
    a_r9_miso_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!fall && !cs_n_s) |=> $stable(miso));

endmodule

// File: rtl/spi_regs_bank.sv
module spi_regs_bank
    import spi_regs_pkg::*;
#(
    parameter word_t       SIGNATURE     = 16'hCAFE,
    parameter word_t       REVISION      = 16'd4,
    parameter word_t       OLDEST_COMPAT = 16'd2,
    parameter logic [31:0] BUILD_CODE    = 32'h1910_2A7C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wr_req_t           wr_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rx_lock_s,
    input  logic              tx_lock_s,
    output word_t             rd_data,
    output logic              dac_excl,
    output logic              xcvr_rst
);

    logic  glb_q;
    word_t scratch_q;
    logic  wr_mapped;

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_q     <= 1'b0;
            scratch_q <= '0;
            dac_excl  <= 1'b0;
            xcvr_rst  <= 1'b0;
        end else begin
            if (wr_en && wr_req.addr == A_GLB) glb_q <= wr_req.data[GLB_BIT];
            if (glb_q) begin
                scratch_q <= '0;
                dac_excl  <= 1'b0;
                xcvr_rst  <= 1'b0;
            end else if (wr_en) begin
                case (wr_req.addr)
                    A_SCRATCH: scratch_q <= wr_req.data;
                    A_CLKPATH: dac_excl  <= wr_req.data[EXCL_BIT];
                    A_XCVR:    xcvr_rst  <= wr_req.data[XRST_BIT];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_SIG:     rd_data = SIGNATURE;
            A_REV:     rd_data = REVISION;
            A_COMPAT:  rd_data = OLDEST_COMPAT;
            A_BLD_LO:  rd_data = BUILD_CODE[15:0];
            A_BLD_HI:  rd_data = BUILD_CODE[31:16];
            A_SCRATCH: rd_data = scratch_q;
            A_GLB:     rd_data = place_bit(GLB_BIT, glb_q);
            A_CLKPATH: rd_data = place_bit(EXCL_BIT, dac_excl);
            A_STATUS:  rd_data = place_bit(RXLK_BIT, rx_lock_s) | place_bit(TXLK_BIT, tx_lock_s);
            A_XCVR:    rd_data = place_bit(XRST_BIT, xcvr_rst);
            default:   rd_data = '0;
        endcase
    end

    always_comb begin
        case (wr_req.addr)
            A_SCRATCH, A_GLB, A_CLKPATH, A_XCVR: wr_mapped = 1'b1;
            default:                             wr_mapped = 1'b0;
        endcase
    end

    // R5: a held clear empties the dependent registers on the next cycle
    a_r5_clear_holds: assert property (@(posedge clk) disable iff (rst)
        glb_q |=> (scratch_q == '0 && !dac_excl && !xcvr_rst));

    // R8: the hard reset rises only after a write to its register
    a_r8_xrst_by_write: assert property (@(posedge clk) disable iff (rst)
        $rose(xcvr_rst) |-> $past(wr_en && wr_req.addr == A_XCVR));

    // R8: without a write or clear the hard reset keeps its level
    a_r8_xrst_holds: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !glb_q) |=> $stable(xcvr_rst));

    // R6: the clock-path bit rises only after a write to its register
    a_r6_excl_by_write: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_excl) |-> $past(wr_en && wr_req.addr == A_CLKPATH));

    // R11: a write to an unmapped address leaves all storage alone
    a_r11_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_mapped && !glb_q) |=>
            ($stable(scratch_q) && $stable(dac_excl) && $stable(xcvr_rst) && $stable(glb_q)));

endmodule

// File: rtl/spi_ctrl_regfile.sv
module spi_ctrl_regfile
    import spi_regs_pkg::*;
#(
    parameter word_t       SIGNATURE     = 16'hCAFE,
    parameter word_t       REVISION      = 16'd4,
    parameter word_t       OLDEST_COMPAT = 16'd2,
    parameter logic [31:0] BUILD_CODE    = 32'h1910_2A7C,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    input  logic rx_lo_locked,
    input  logic tx_lo_locked,
    output logic dac_owns_vcxo,
    output logic xcvr_hard_reset
);

    logic    sclk_s, cs_n_s, mosi_s;
    logic    rx_s, tx_s;
    hdr_t    hdr;
    logic    wr_en;
    wr_req_t wr_req;
    word_t   rd_data;

    spi_regs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_spi_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q   ({sclk_s, cs_n_s, mosi_s})
    );

    spi_regs_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b00)) u_stat_sync (
        .clk (clk),
        .rst (rst),
        .d   ({tx_lo_locked, rx_lo_locked}),
        .q   ({tx_s, rx_s})
    );

    spi_regs_frontend u_front (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sclk_s),
        .cs_n_s  (cs_n_s),
        .mosi_s  (mosi_s),
        .rd_data (rd_data),
        .hdr     (hdr),
        .wr_en   (wr_en),
        .wr_req  (wr_req),
        .miso    (spi_miso)
    );

    spi_regs_bank #(
        .SIGNATURE     (SIGNATURE),
        .REVISION      (REVISION),
        .OLDEST_COMPAT (OLDEST_COMPAT),
        .BUILD_CODE    (BUILD_CODE)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_req    (wr_req),
        .rd_addr   (hdr.addr),
        .rx_lock_s (rx_s),
        .tx_lock_s (tx_s),
        .rd_data   (rd_data),
        .dac_excl  (dac_owns_vcxo),
        .xcvr_rst  (xcvr_hard_reset)
    );

endmodule

// File: tb/spi_ctrl_regfile_test.sv
module spi_ctrl_regfile_test;

    localparam int HALF = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic rx_lk = 1'b0, tx_lk = 1'b0;
    logic excl, xrst;

    int checks = 0;
    int errors = 0;
    bit settled = 0;
    bit done = 0;

    // behavioural reference state
    bit        m_glb = 0, m_excl = 0, m_xrst = 0;
    bit [15:0] m_scr = 0;

    spi_ctrl_regfile uut (
        .clk             (clk),
        .rst             (rst),
        .spi_sclk        (sclk),
        .spi_cs_n        (cs_n),
        .spi_mosi        (mosi),
        .spi_miso        (miso),
        .rx_lo_locked    (rx_lk),
        .tx_lo_locked    (tx_lk),
        .dac_owns_vcxo   (excl),
        .xcvr_hard_reset (xrst)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic bit [15:0] model_rd(input bit [6:0] a);
        case (a)
            7'h00: return 16'hCAFE;
            7'h01: return 16'd4;
            7'h02: return 16'd2;
            7'h03: return 16'h2A7C;
            7'h04: return 16'h1910;
            7'h05: return m_scr;
            7'h10: return {15'b0, m_glb};
            7'h11: return {11'b0, m_excl, 4'b0};
            7'h12: return {11'b0, tx_lk, 3'b0, rx_lk};
            7'h13: return {15'b0, m_xrst};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model_wr(input bit [6:0] a, input bit [15:0] d);
        if (a == 7'h10) m_glb = d[0];
        else if (!m_glb) begin
            case (a)
                7'h05: m_scr  = d;
                7'h11: m_excl = d[4];
                7'h13: m_xrst = d[0];
                default: ;
            endcase
        end
        if (m_glb) begin
            m_scr = 0; m_excl = 0; m_xrst = 0;
        end
    endtask

    task automatic xfer(input logic [23:0] frame, input int nbits, output logic [23:0] got);
        settled = 0;
        got = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? frame[23-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 24) got[23-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        if (nbits == 24 && !frame[23]) model_wr(frame[22:16], frame[15:0]);
        repeat (3*HALF) @(negedge clk);
        settled = 1;
    endtask

    task automatic spi_wr(input bit [6:0] a, input bit [15:0] d, input string req);
        logic [23:0] g;
        xfer({1'b0, a, d}, 24, g);
        check({req, " R9"}, "miso during write frame", g, 24'h0);
    endtask

    task automatic spi_rd(input bit [6:0] a, input string req);
        logic [23:0] g;
        xfer({1'b1, a, 16'h0}, 24, g);
        check("R9", "miso during header", {24'h0, g[23:16]}, 32'h0);
        check(req, $sformatf("read addr 0x%0h", a), {16'h0, g[15:0]}, {16'h0, model_rd(a)});
    endtask

    // continuous comparison of the control pins against the model
    always @(negedge clk) begin
        if (settled && !rst && !done) begin
            check("R6", "dac_owns_vcxo pin", {31'b0, excl}, {31'b0, m_excl});
            check("R8", "xcvr_hard_reset pin", {31'b0, xrst}, {31'b0, m_xrst});
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] g;
        repeat (5) @(negedge clk);
        // R12: state during and right after reset
        check("R12", "miso in reset", {31'b0, miso}, 32'h0);
        check("R12", "excl in reset", {31'b0, excl}, 32'h0);
        check("R12", "xrst in reset", {31'b0, xrst}, 32'h0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        settled = 1;

        // R1 R2 R3: identity words
        spi_rd(7'h00, "R1 R2");
        spi_rd(7'h01, "R2");
        spi_rd(7'h02, "R3");
        spi_rd(7'h03, "R3");
        spi_rd(7'h04, "R3");
        spi_wr(7'h00, 16'h1234, "R2");
        spi_wr(7'h01, 16'hFFFF, "R2");
        spi_rd(7'h00, "R2");
        spi_rd(7'h01, "R2");
        spi_rd(7'h05, "R12");

        // R4: scratch
        spi_wr(7'h05, 16'hA5C3, "R4");
        spi_rd(7'h05, "R4");
        spi_wr(7'h05, 16'h5A3C, "R4");
        spi_rd(7'h05, "R4");

        // R6: clock-path bit
        spi_wr(7'h11, 16'hFFFF, "R6");
        spi_rd(7'h11, "R6");
        spi_wr(7'h11, 16'h0000, "R6");
        spi_rd(7'h11, "R6");
        spi_wr(7'h11, 16'h0010, "R6");

        // R8: hard reset held until cleared
        spi_wr(7'h13, 16'h0001, "R8");
        repeat (100) @(negedge clk);
        spi_rd(7'h13, "R8");
        spi_rd(7'h05, "R8");
        spi_wr(7'h13, 16'h0000, "R8");
        spi_rd(7'h13, "R8");
        spi_wr(7'h13, 16'h0001, "R8");

        // R7: status word
        rx_lk = 1'b1; tx_lk = 1'b0;
        repeat (10) @(negedge clk);
        spi_rd(7'h12, "R7");
        tx_lk = 1'b1;
        repeat (10) @(negedge clk);
        spi_rd(7'h12, "R7");
        rx_lk = 1'b0;
        spi_wr(7'h12, 16'hFFFF, "R7");
        spi_rd(7'h12, "R7");

        // R11: unmapped addresses
        spi_rd(7'h7F, "R11");
        spi_wr(7'h06, 16'hBEEF, "R11");
        spi_rd(7'h06, "R11");
        spi_rd(7'h05, "R11");

        // R10: truncated and overlong frames are dropped
        xfer({1'b0, 7'h05, 16'h0F0F}, 23, g);
        spi_rd(7'h05, "R10");
        xfer({1'b0, 7'h05, 16'hF0F0}, 25, g);
        spi_rd(7'h05, "R10");
        xfer({1'b0, 7'h13, 16'h0000}, 23, g);
        spi_rd(7'h13, "R10");

        // R5: global clear colliding with writes
        spi_wr(7'h10, 16'h0001, "R5");
        spi_rd(7'h10, "R5");
        spi_rd(7'h05, "R5");
        spi_wr(7'h05, 16'h7777, "R5");
        spi_wr(7'h11, 16'h0010, "R5");
        spi_wr(7'h13, 16'h0001, "R5");
        spi_rd(7'h05, "R5");
        spi_rd(7'h13, "R5");
        spi_wr(7'h10, 16'h0000, "R5");
        spi_rd(7'h10, "R5");
        spi_rd(7'h05, "R5");
        spi_wr(7'h05, 16'h4321, "R5");
        spi_rd(7'h05, "R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule